// File: doc/BRIEF.md
# Processor Reset Sequencer

This block sequences a processor core's fetch unit through reset. It watches an asynchronous, active-low core reset request and brings it into the clock domain through a two-flop chain. While the synchronised request stays low, the instruction in progress is dropped. The bus is held idle, and the address register steps up by one word every clock, wrapping at the top of the address space.

When the request is released, the block runs a short fixed sequence:
1. In one cycle, it writes the reached address into the supervisor link register and the current status word into the supervisor saved status register. In the same cycle it forces the mode field to supervisor (`10011`) and sets both interrupt masks.
2. It makes one or two real bus accesses starting from the address that was reached.
3. It issues the first instruction fetch from address zero and flags completion.

A configuration input selects one or two accesses. If the request falls again before the sequence ends, the sequence is abandoned and idle cycles resume from the held address.

Top module: `reset_sequencer`

## Requirements
- R1: A low level on `sys_reset_n` becomes visible through two synchroniser flops. If the input is low at clock edge k, `bus_idle` is first high after edge k+2.
- R2: While the synchronised request is low, `bus_idle` is 1 and `bus_req` is 0. `bus_addr` rises by 4 each cycle.
- R3: The idle-cycle address wraps modulo 2^AW, so 0xFFFFFFFC is followed by 0x00000000.
- R4: The first idle address equals `cur_pc` with its two low bits cleared, sampled at the edge where the idle phase is entered.
- R5: Release is followed by exactly one save cycle. In that cycle `lr_we` and `spsr_we` are 1, `lr_wdata` equals the address the idle phase reached, and `spsr_wdata` equals `cur_status`. No bus request is made in that cycle.
- R6: In the save cycle, `mode_we` is 1, `mode_val` is 5'b10011, and `irq_mask` and `fiq_mask` are both 1. Outside that cycle all three are 0.
- R7: After the save cycle, `bus_req` is high with `bus_idle` low for one cycle at the reached address when `two_access` is 0. When `two_access` is 1 it is high for two cycles, at the reached address and then that address plus 4.
- R8: The cycle after the accesses drives `bus_req`=1, `bus_addr`=0 and `done`=1 for one cycle. The block then returns to normal running.
- R9: While `rst_n` is low (synchronous), the synchroniser reads as "in reset", the block sits in the idle phase and the address register is 0.
- R10: During normal running, `bus_req`, `bus_idle`, all write strobes and `done` are 0, and `bus_addr` is 0.
- R11: If the synchronised request goes low during the save, access or fetch cycles, the next cycle is an idle cycle at the unchanged held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sys_reset_n | input | 1 | Asynchronous active-low core reset request |
| two_access | input | 1 | 1 selects two post-reset accesses, 0 selects one |
| cur_pc | input | AW | Program counter of the running core |
| cur_status | input | SW | Current status word of the core |
| bus_addr | output | AW | Bus address |
| bus_req | output | 1 | Real bus transfer requested |
| bus_idle | output | 1 | Idle bus cycle |
| lr_we | output | 1 | Supervisor link register write strobe |
| lr_wdata | output | AW | Value written to the link register |
| spsr_we | output | 1 | Supervisor saved status write strobe |
| spsr_wdata | output | SW | Value written to the saved status register |
| mode_we | output | 1 | Status mode and mask write strobe |
| mode_val | output | 5 | Forced mode field |
| irq_mask | output | 1 | Normal interrupt mask value |
| fiq_mask | output | 1 | Fast interrupt mask value |
| done | output | 1 | Fetch from address zero issued |

## Verification
The embedded assertions check, on every cycle:
- idle cycles never request the bus, and successive idle addresses differ by exactly one word modulo the address width;
- a save cycle always carries all three strobes and is followed by an access at the same address;
- `done` coincides with a request at address zero and never lasts two cycles.

Only the bench's scenarios show the rest. This covers the two-edge synchroniser latency and the starting address taken from `cur_pc`. It also covers the choice between one and two accesses, the wrap across the top of the address space, and abandoning a sequence when the request falls mid-way. The bench compares every output against a behavioural model for reset pulses of several lengths.

// File: rtl/rseq_pkg.sv
// Package: shared phase encoding and constants for the reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rseq_pkg;

    typedef enum logic [2:0] {
        PH_RUN   = 3'd0,
        PH_IDLE  = 3'd1,
        PH_SAVE  = 3'd2,
        PH_ACC1  = 3'd3,
        PH_ACC2  = 3'd4,
        PH_FETCH = 3'd5
    } rseq_phase_e;

    typedef enum logic [1:0] {
        AOP_HOLD = 2'd0,
        AOP_LOAD = 2'd1,
        AOP_INC  = 2'd2
    } rseq_aop_e;

    localparam logic [4:0] SUPERVISOR_MODE = 5'b10011;

endpackage

// File: rtl/rseq_sync.sv
// Module: rseq_sync
// Brings an asynchronous active-low level into the clock domain through a
// chain of STAGES flops. Block reset forces the chain to the asserted (0)
// state, so the core is held in reset until the request is seen high.
// Assumes: STAGES >= 2.
module rseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rseq_addr.sv
// Module: rseq_addr
// Word address register: loads a word-aligned copy of the running PC,
// steps by one word with natural wrap at 2^AW, or holds.
// Assumes: WORD_BYTES is a power of two no larger than 2^AW.
module rseq_addr
    import rseq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rseq_aop_e     op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);
    localparam int        LSB  = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << LSB) - 1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    // Choose the next address from the requested operation.
    always_comb begin
        unique case (op)
            AOP_LOAD: addr_d = load_val & ALIGN_MASK;
            AOP_INC:  addr_d = addr_q + STEP;
            default:  addr_d = addr_q;
        endcase
    end

    // Hold the address; cleared by block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/rseq_fsm.sv
// Module: rseq_fsm
// Phase controller: run -> idle while reset is requested -> save ->
// one or two accesses -> fetch from zero -> run. A fresh request at any
// post-release phase abandons the sequence back to idle.
// Assumes: req_n is already synchronous to clk.
module rseq_fsm
    import rseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_n,
    input  logic        two_access,
    output rseq_phase_e phase,
    output rseq_aop_e   aop
);
    rseq_phase_e ph_q;
    rseq_phase_e ph_d;

    // Next phase and address operation.
    always_comb begin
        ph_d = ph_q;
        aop  = AOP_HOLD;
        unique case (ph_q)
            PH_RUN: begin
                aop = AOP_LOAD;
                if (!req_n) ph_d = PH_IDLE;
            end
            PH_IDLE: begin
                aop = AOP_INC;
                if (req_n) ph_d = PH_SAVE;
            end
            PH_SAVE: begin
                ph_d = req_n ? PH_ACC1 : PH_IDLE;
            end
            PH_ACC1: begin
                if (!req_n) begin
                    ph_d = PH_IDLE;
                end else if (two_access) begin
                    aop  = AOP_INC;
                    ph_d = PH_ACC2;
                end else begin
                    ph_d = PH_FETCH;
                end
            end
            PH_ACC2: begin
                ph_d = req_n ? PH_FETCH : PH_IDLE;
            end
            PH_FETCH: begin
                ph_d = req_n ? PH_RUN : PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register; block reset parks in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;

    // An idle phase always steps the address (R2).
    p_idle_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE) |-> (aop == AOP_INC));

    // Leaving save always goes to an access or back to idle (R7, R11).
    p_save_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SAVE) |=> (ph_q == PH_ACC1 || ph_q == PH_IDLE));
endmodule

// File: rtl/reset_sequencer.sv
// Module: reset_sequencer (top)
// Sequences a fetch unit through core reset: idle bus cycles on rising word
// addresses while the request is low, then save/force, one or two accesses,
// and a fetch from address zero.
// Assumes: sys_reset_n may be asynchronous; every other input is synchronous.
module reset_sequencer
    import rseq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SW          = 32,
    parameter int WORD_BYTES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_reset_n,
    input  logic          two_access,
    input  logic [AW-1:0] cur_pc,
    input  logic [SW-1:0] cur_status,
    output logic [AW-1:0] bus_addr,
    output logic          bus_req,
    output logic          bus_idle,
    output logic          lr_we,
    output logic [AW-1:0] lr_wdata,
    output logic          spsr_we,
    output logic [SW-1:0] spsr_wdata,
    output logic          mode_we,
    output logic [4:0]    mode_val,
    output logic          irq_mask,
    output logic          fiq_mask,
    output logic          done
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic          req_sync_n;
    rseq_phase_e   phase;
    rseq_aop_e     aop;
    logic [AW-1:0] addr_q;
    logic          in_save;

    rseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (sys_reset_n),
        .sync_n  (req_sync_n)
    );

    rseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_sync_n),
        .two_access (two_access),
        .phase      (phase),
        .aop        (aop)
    );

    rseq_addr #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (aop),
        .load_val (cur_pc),
        .addr     (addr_q)
    );

    assign in_save = (phase == PH_SAVE);

    // Bus-side decode of the current phase.
    always_comb begin
        bus_idle = (phase == PH_IDLE) || in_save;
        bus_req  = (phase == PH_ACC1) || (phase == PH_ACC2) || (phase == PH_FETCH);
        done     = (phase == PH_FETCH);
        bus_addr = (phase == PH_RUN || phase == PH_FETCH) ? '0 : addr_q;
    end

    // Register-file side: banked saves and forced mode in the save cycle.
    always_comb begin
        lr_we      = in_save;
        lr_wdata   = in_save ? addr_q : '0;
        spsr_we    = in_save;
        spsr_wdata = in_save ? cur_status : '0;
        mode_we    = in_save;
        mode_val   = in_save ? SUPERVISOR_MODE : 5'b0;
        irq_mask   = in_save;
        fiq_mask   = in_save;
    end

    // Idle cycles never ask for a real transfer (R2).
    p_idle_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !bus_req);

    // Back-to-back idle cycles advance one word, wrapping (R2, R3).
    p_idle_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase == PH_IDLE) && $past(rst_n))
        |-> (bus_addr == AW'($past(bus_addr) + STEP)));

    // The save cycle carries all three strobes (R5, R6).
    p_save_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (spsr_we && mode_we && mode_val == SUPERVISOR_MODE));

    // A save followed by a running request is an access at the saved address (R7).
    p_save_then_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && req_sync_n) |=> (bus_req && bus_addr == $past(lr_wdata)));

    // Completion is a fetch from zero (R8).
    p_done_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_req && bus_addr == '0));

    // Completion lasts a single cycle (R8).
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
    localparam int AW = 32;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_reset_n = 1'b0;
    logic          two_access = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic [SW-1:0] cur_status = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_req, bus_idle, lr_we, spsr_we, mode_we;
    logic          irq_mask, fiq_mask, done;
    logic [AW-1:0] lr_wdata;
    logic [SW-1:0] spsr_wdata;
    logic [4:0]    mode_val;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;
    string scen_tag = "R9";

    always #2.5 clk = ~clk;  // 200 MHz

    reset_sequencer #(.AW(AW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .sys_reset_n(sys_reset_n),
        .two_access(two_access), .cur_pc(cur_pc), .cur_status(cur_status),
        .bus_addr(bus_addr), .bus_req(bus_req), .bus_idle(bus_idle),
        .lr_we(lr_we), .lr_wdata(lr_wdata), .spsr_we(spsr_we),
        .spsr_wdata(spsr_wdata), .mode_we(mode_we), .mode_val(mode_val),
        .irq_mask(irq_mask), .fiq_mask(fiq_mask), .done(done)
    );

    // Behavioural reference: 0 run, 1 idle, 2 save, 3 access1, 4 access2, 5 fetch
    int  m_ph = 1;
    longint unsigned m_addr = 0;
    bit  m_s0 = 0, m_s1 = 0;
    localparam longint unsigned MOD = 64'd1 << AW;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_ph = 1; m_addr = 0;
        end else begin
            case (m_ph)
                0: begin m_addr = cur_pc & ~32'h3; if (!m_s1) m_ph = 1; end
                1: begin m_addr = (m_addr + 4) % MOD; if (m_s1) m_ph = 2; end
                2: m_ph = m_s1 ? 3 : 1;
                3: if (!m_s1) m_ph = 1;
                   else if (two_access) begin m_addr = (m_addr + 4) % MOD; m_ph = 4; end
                   else m_ph = 5;
                4: m_ph = m_s1 ? 5 : 1;
                default: m_ph = m_s1 ? 0 : 1;
            endcase
            m_s1 = m_s0;
            m_s0 = sys_reset_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            longint unsigned e_addr;
            bit e_idle, e_req, e_save, e_done;
            string t;
            e_idle = (m_ph == 1) || (m_ph == 2);
            e_req  = (m_ph >= 3);
            e_save = (m_ph == 2);
            e_done = (m_ph == 5);
            e_addr = (m_ph == 0 || m_ph == 5) ? 0 : m_addr;
            case (m_ph)
                0: t = "R10"; 1: t = "R2"; 2: t = "R5";
                3, 4: t = "R7"; default: t = "R8";
            endcase
            t = {t, "/", scen_tag};
            chk(bus_addr == e_addr[AW-1:0], {t, " bus_addr"}, bus_addr, e_addr);
            chk(bus_idle == e_idle && bus_req == e_req, {t, " idle/req"},
                {bus_idle, bus_req}, {e_idle, e_req});
            chk(done == e_done, {t, " done"}, done, e_done);
            chk(lr_we == e_save && spsr_we == e_save, {t, " R5 strobes"},
                {lr_we, spsr_we}, {e_save, e_save});
            if (e_save) begin
                chk(lr_wdata == m_addr[AW-1:0], "R5 lr_wdata", lr_wdata, m_addr);
                chk(spsr_wdata == cur_status, "R5 spsr_wdata", spsr_wdata, cur_status);
            end
            chk(mode_we == e_save && irq_mask == e_save && fiq_mask == e_save &&
                mode_val == (e_save ? 5'b10011 : 5'b0), {t, " R6 mode"},
                {mode_we, irq_mask, fiq_mask, mode_val}, {e_save, e_save, e_save,
                (e_save ? 5'b10011 : 5'b0)});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    // Hold the core reset request low for len cycles, then release and settle.
    task automatic pulse(input int len, input bit two, input logic [AW-1:0] pc);
        cur_pc = pc; two_access = two;
        sys_reset_n = 1'b0;
        step(2);
        chk(bus_idle == 1'b0, "R1 latency before", bus_idle, 0);
        step(1);
        chk(bus_idle == 1'b1, "R1 latency after", bus_idle, 1);
        chk(bus_addr == (pc & ~32'h3), "R4 first idle addr", bus_addr, pc & ~32'h3);
        step(len > 1 ? len - 1 : 0);
        sys_reset_n = 1'b1;
        step(10);
    endtask

    initial begin
        cur_status = 32'hA5C3_0F1E;
        step(3);
        // R9: block reset state
        chk(bus_idle == 1'b1 && bus_req == 1'b0 && bus_addr == '0, "R9 reset state",
            {bus_idle, bus_req, bus_addr}, {1'b1, 1'b0, 32'h0});
        @(negedge clk); #1; rst_n = 1'b1;
        step(4);
        sys_reset_n = 1'b1;
        step(10);
        scen_tag = "R7";
        pulse(1, 1'b0, 32'h0000_1003);
        pulse(2, 1'b1, 32'h0000_2000);
        cur_status = 32'h1234_5678;
        pulse(5, 1'b0, 32'h8000_0012);
        pulse(12, 1'b1, 32'h0000_0040);
        scen_tag = "R3";
        pulse(6, 1'b1, 32'hFFFF_FFF6);
        // R11: re-assert during the post-release sequence
        scen_tag = "R11";
        cur_pc = 32'h0000_3000; two_access = 1'b1;
        sys_reset_n = 1'b0; step(6);
        sys_reset_n = 1'b1; step(3);
        sys_reset_n = 1'b0; step(1);
        sys_reset_n = 1'b1; step(4);
        sys_reset_n = 1'b0; step(5);
        sys_reset_n = 1'b1; step(12);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule